// File: doc/BRIEF.md
# Triangular-Dither DAC Code Generator

This block turns a stream of 24-bit samples into 16-bit DAC codes. It adds a pseudo-random dither and a signed DC offset to every sample and then keeps only the top 16 bits. The offset can move small signals away from the major code transitions of the converter. The dither spreads the truncation error over several coarse steps. Averaged by the analog filter after the DAC, the output then carries resolution below one DAC LSB. A damaged code transition in the converter is also averaged out rather than hit every time.

The dither comes from two 32-bit Galois shift registers that step on every running clock. The low bits of each register give two independent uniform values. Their sum, moved down by one step size, has a triangular distribution around zero. A small amplitude input picks how many low bits are used, and that sets the peak-to-peak spread. Both registers restart from fixed seeds at reset, so every run after reset yields the same code sequence. There is no feedback path: the block is a plain feed-forward adder with one output register.

Top module: `dither_adder`

## Requirements
- R1: While `rstN` is low, `dacCode` is 0 and the two shift registers hold their seeds, 32'h1D872B41 (A) and 32'h9E3779B9 (B). On the first clock edge after `rstN` rises, nothing advances and `dacCode` stays 0. From the second edge on, the block runs on every clock.
- R2: With `ampSel` = 0 and `dcOffset` = 0, `dacCode` equals bits [23:8] of `inSample` from the previous running edge. This is a one-register latency.
- R3: `dcOffset` is a two's-complement value. It is added to `inSample`, which is unsigned, before truncation.
- R4: A sum above 24'hFFFFFF saturates, and `dacCode` becomes 16'hFFFF.
- R5: A sum below zero saturates, and `dacCode` becomes 16'h0000.
- R6: Each shift register advances once per running edge. The step is a right shift, and when the bit shifted out is 1 the new state is XORed with 32'h80200003.
- R7: For `ampSel` = N with 1 ≤ N ≤ 12, the dither is (A mod 2^N) + (B mod 2^N) − 2^N, taken from the register states before the edge. Any `ampSel` above 12 acts as 12. `ampSel` = 0 gives zero dither.
- R8: Let S be the sum of `inSample` and `dcOffset`. While running, `dacCode` lies between the saturated values of (S − 2^N)>>8 and (S + 2^N − 2)>>8. With N = 11 and a steady mid-scale input, the code spreads over at least 4 distinct coarse steps.
- R9: After a new reset, the same input stream produces the same `dacCode` sequence.
- R10: Neither shift register ever reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| inSample | input | 24 | Unsigned input sample |
| dcOffset | input | 24 | Two's-complement DC offset |
| ampSel | input | 4 | Dither width N in bits (0 disables, values above 12 act as 12) |
| dacCode | output | 16 | Registered DAC code |

## Verification
The bench builds the block with its default parameters: 24-bit input, 16-bit output, a 12-bit maximum dither width, and the stated tap mask and seeds. These values make clamped amplitude settings reachable (`ampSel` 13 to 15). They also let the bench drive offsets far enough to force saturation at both ends of the code range. With 11-bit dither the code must move across eight coarse steps either side of mid-scale, which exposes a wrong dither span or centring. The bench models both shift registers from the stated polynomial and seeds, so it can check each cycle's code exactly and replay the sequence after a second reset.

// File: rtl/dith_pkg.sv
package dith_pkg;

  // Strobes from the sequencing logic to the arithmetic path.
  typedef struct packed {
    logic step;   // advance both shift registers
    logic load;   // capture a new output code
  } dithStrobe_t;

  localparam logic [31:0] DEF_TAPS   = 32'h8020_0003;
  localparam logic [31:0] DEF_SEED_A = 32'h1D87_2B41;
  localparam logic [31:0] DEF_SEED_B = 32'h9E37_79B9;

endpackage

// File: rtl/dith_ctrl.sv
module dith_ctrl
  import dith_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output dithStrobe_t strobe
);

  logic running;

  // One idle edge after reset, then continuous operation.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= 1'b1;
  end

  always_comb begin
    strobe.step = running;
    strobe.load = running;
  end

endmodule

// File: rtl/dith_lfsr.sv
module dith_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] feedback;

  always_comb feedback = state[0] ? TAPS : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= SEED;
    else if (step) state <= {1'b0, state[W-1:1]} ^ feedback;
  end

endmodule

// File: rtl/dith_datapath.sv
module dith_datapath
  import dith_pkg::*;
#(
  parameter int                IN_W     = 24,
  parameter int                OUT_W    = 16,
  parameter int                MAX_BITS = 12,
  parameter int                LFSR_W   = 32,
  parameter logic [LFSR_W-1:0] TAPS     = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED_A   = DEF_SEED_A,
  parameter logic [LFSR_W-1:0] SEED_B   = DEF_SEED_B,
  localparam int               AMP_W    = $clog2(MAX_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dithStrobe_t       strobe,
  input  logic [IN_W-1:0]   inSample,
  input  logic [IN_W-1:0]   dcOffset,
  input  logic [AMP_W-1:0]  ampSel,
  output logic [OUT_W-1:0]  dacCode,
  output logic [LFSR_W-1:0] stateA,
  output logic [LFSR_W-1:0] stateB
);

  localparam int DITH_W = MAX_BITS + 2;
  localparam int SUM_W  = IN_W + 3;

  logic [LFSR_W-1:0]         lfsrState [2];
  logic [MAX_BITS-1:0]       uniform   [2];
  logic [AMP_W-1:0]          ampEff;
  logic [MAX_BITS:0]         unitStep;
  logic [MAX_BITS:0]         lowMask;
  logic [MAX_BITS:0]         pairSum;
  logic signed [DITH_W-1:0]  dither;
  logic signed [SUM_W-1:0]   total;
  logic [IN_W-1:0]           clipped;

  always_comb begin
    ampEff   = (ampSel > AMP_W'(MAX_BITS)) ? AMP_W'(MAX_BITS) : ampSel;
    unitStep = (MAX_BITS + 1)'(1) << ampEff;
    lowMask  = unitStep - 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : genSource
    dith_lfsr #(
      .W    (LFSR_W),
      .TAPS (TAPS),
      .SEED ((g == 0) ? SEED_A : SEED_B)
    ) uLfsr (
      .clk   (clk),
      .rstN  (rstN),
      .step  (strobe.step),
      .state (lfsrState[g])
    );
    always_comb uniform[g] = lfsrState[g][MAX_BITS-1:0] & lowMask[MAX_BITS-1:0];
  end

  assign stateA = lfsrState[0];
  assign stateB = lfsrState[1];

  always_comb begin
    pairSum = {1'b0, uniform[0]} + {1'b0, uniform[1]};
    if (ampEff == '0) dither = '0;
    else              dither = $signed({1'b0, pairSum}) - $signed({1'b0, unitStep});

    total = $signed({{(SUM_W-IN_W){1'b0}}, inSample})
          + $signed({{(SUM_W-IN_W){dcOffset[IN_W-1]}}, dcOffset})
          + $signed({{(SUM_W-DITH_W){dither[DITH_W-1]}}, dither});

    if (total[SUM_W-1])                clipped = '0;
    else if (|total[SUM_W-2:IN_W])     clipped = '1;
    else                               clipped = total[IN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dacCode <= '0;
    else if (strobe.load) dacCode <= clipped[IN_W-1 -: OUT_W];
  end

endmodule

// File: rtl/dither_adder.sv
module dither_adder
  import dith_pkg::*;
#(
  parameter int                IN_W     = 24,
  parameter int                OUT_W    = 16,
  parameter int                MAX_BITS = 12,
  parameter int                LFSR_W   = 32,
  parameter logic [LFSR_W-1:0] TAPS     = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED_A   = DEF_SEED_A,
  parameter logic [LFSR_W-1:0] SEED_B   = DEF_SEED_B,
  localparam int               AMP_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  inSample,
  input  logic [IN_W-1:0]  dcOffset,
  input  logic [AMP_W-1:0] ampSel,
  output logic [OUT_W-1:0] dacCode
);

  dithStrobe_t       strobe;
  logic [LFSR_W-1:0] stateA;
  logic [LFSR_W-1:0] stateB;

  dith_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  dith_datapath #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .MAX_BITS (MAX_BITS),
    .LFSR_W   (LFSR_W),
    .TAPS     (TAPS),
    .SEED_A   (SEED_A),
    .SEED_B   (SEED_B)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inSample (inSample),
    .dcOffset (dcOffset),
    .ampSel   (ampSel),
    .dacCode  (dacCode),
    .stateA   (stateA),
    .stateB   (stateB)
  );

endmodule

// File: rtl/dither_adder_chk.sv
module dither_adder_chk
  import dith_pkg::*;
#(
  parameter int                IN_W     = 24,
  parameter int                OUT_W    = 16,
  parameter int                MAX_BITS = 12,
  parameter int                LFSR_W   = 32,
  parameter logic [LFSR_W-1:0] SEED_A   = DEF_SEED_A,
  parameter logic [LFSR_W-1:0] SEED_B   = DEF_SEED_B,
  localparam int               AMP_W    = $clog2(MAX_BITS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input dithStrobe_t       strobe,
  input logic [IN_W-1:0]   inSample,
  input logic [IN_W-1:0]   dcOffset,
  input logic [AMP_W-1:0]  ampSel,
  input logic [OUT_W-1:0]  dacCode,
  input logic [LFSR_W-1:0] stateA,
  input logic [LFSR_W-1:0] stateB
);

  localparam int SUM_W = IN_W + 3;

  logic [AMP_W-1:0]        chkAmp;
  logic signed [SUM_W-1:0] span, base, loSum, hiSum;
  logic [OUT_W-1:0]        loCode, hiCode;

  function automatic logic [OUT_W-1:0] clampCode(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] top;
    top = $signed({{(SUM_W-IN_W){1'b0}}, {IN_W{1'b1}}});
    if (v < 0)        return '0;
    else if (v > top) return '1;
    else              return v[IN_W-1 -: OUT_W];
  endfunction

  always_comb begin
    chkAmp = (ampSel > AMP_W'(MAX_BITS)) ? AMP_W'(MAX_BITS) : ampSel;
    span   = (chkAmp == '0) ? '0 : (SUM_W'(1) << chkAmp);
    base   = $signed({{(SUM_W-IN_W){1'b0}}, inSample})
           + $signed({{(SUM_W-IN_W){dcOffset[IN_W-1]}}, dcOffset});
    loSum  = base - span;
    hiSum  = (chkAmp == '0) ? base : base + span - 2;
    loCode = clampCode(loSum);
    hiCode = clampCode(hiSum);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (dacCode == '0)); // R1

  AST_SEED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step |-> (stateA == SEED_A && stateB == SEED_B)); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && $past(ampSel) == '0 && $past(dcOffset) == '0)
      |-> (dacCode == $past(inSample[IN_W-1 -: OUT_W]))); // R2

  AST_LFSR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (stateA != $past(stateA) && stateB != $past(stateB))); // R6

  AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.load) |-> (dacCode >= $past(loCode) && dacCode <= $past(hiCode))); // R8

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stateA != '0 && stateB != '0)); // R10

endmodule

bind dither_adder dither_adder_chk #(
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .MAX_BITS (MAX_BITS),
  .LFSR_W   (LFSR_W),
  .SEED_A   (SEED_A),
  .SEED_B   (SEED_B)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .inSample (inSample),
  .dcOffset (dcOffset),
  .ampSel   (ampSel),
  .dacCode  (dacCode),
  .stateA   (stateA),
  .stateB   (stateB)
);

// File: tb/dither_adder_test.sv
module dither_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAPS  = 32'h8020_0003;
  localparam logic [31:0] SEEDA = 32'h1D87_2B41;
  localparam logic [31:0] SEEDB = 32'h9E37_79B9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] inS = '0;
  logic [23:0] offS = '0;
  logic [3:0]  ampS = '0;
  logic [15:0] dacCode;

  int nChecks = 0;
  int nErrors = 0;

  logic [31:0] mA, mB;
  logic        mRun;
  logic [15:0] mLast;
  logic [15:0] got, exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_adder uut (
    .clk      (clk),
    .rstN     (rstN),
    .inSample (inS),
    .dcOffset (offS),
    .ampSel   (ampS),
    .dacCode  (dacCode)
  );

  function automatic logic [31:0] nextState(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  function automatic logic [15:0] modelCode(input logic [23:0] in, input logic [23:0] off,
                                            input int amp, input logic [31:0] a,
                                            input logic [31:0] b);
    longint n, d, m, t;
    n = (amp > 12) ? 12 : amp;
    d = 0;
    if (n > 0) begin
      m = (longint'(1) << n) - 1;
      d = (longint'(a) & m) + (longint'(b) & m) - (longint'(1) << n);
    end
    t = longint'(in) + longint'($signed(off)) + d;
    if (t < 0) t = 0;
    if (t > 64'sd16777215) t = 64'sd16777215;
    return 16'(t >>> 8);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] want);
    nChecks++;
    if (act !== want) begin
      nErrors++;
      $display("FAIL %s: got %h expected %h", req, act, want);
    end
  endtask

  // One clock: drive at the falling edge, sample at the next falling edge.
  task automatic tick(input logic [23:0] in, input logic [23:0] off, input int amp);
    inS  = in;
    offS = off;
    ampS = 4'(amp);
    exp  = mRun ? modelCode(in, off, amp, mA, mB) : mLast;
    @(posedge clk);
    @(negedge clk);
    got   = dacCode;
    mLast = exp;
    if (mRun) begin
      mA = nextState(mA);
      mB = nextState(mB);
    end
    mRun = 1'b1;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN  = 1'b0;
    mA    = SEEDA;
    mB    = SEEDB;
    mRun  = 1'b0;
    mLast = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset code", dacCode, 16'h0000);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    applyReset();
    tick(24'hABCDEF, 24'h0, 0);
    check("R1 idle first edge", got, 16'h0000);
    tick(24'hABCDEF, 24'h0, 0);
    check("R1 first running code", got, 16'hABCD);
  endtask

  task automatic testPassThrough();
    tick(24'h123456, 24'h0, 0); check("R2 pass", got, 16'h1234);
    tick(24'h0000FF, 24'h0, 0); check("R2 drop low byte", got, 16'h0000);
    tick(24'hFFFFFF, 24'h0, 0); check("R2 full scale", got, 16'hFFFF);
    tick(24'h8001A0, 24'h0, 0); check("R2 mid", got, 16'h8001);
  endtask

  task automatic testOffset();
    tick(24'h100000, 24'h012400, 0); check("R3 positive offset", got, 16'h1124);
    tick(24'h100000, 24'hFFFF00, 0); check("R3 negative offset", got, 16'h0FFF);
    tick(24'h0000F0, 24'h000010, 0); check("R3 carry into code", got, 16'h0001);
  endtask

  task automatic testSaturation();
    tick(24'hFFFF00, 24'h001000, 0); check("R4 clamp high", got, 16'hFFFF);
    tick(24'hFFFFFF, 24'h7FFFFF, 12); check("R4 clamp high dithered", got, 16'hFFFF);
    tick(24'h000010, 24'hFFFF00, 0); check("R5 clamp low", got, 16'h0000);
    tick(24'h000000, 24'h800000, 12); check("R5 clamp low dithered", got, 16'h0000);
  endtask

  task automatic testDitherModel();
    for (int i = 0; i < 300; i++) begin
      tick(24'h400000 + 24'(i * 1237), 24'h000120, 11);
      check("R6 R7 dithered code n=11", got, exp);
    end
    for (int i = 0; i < 40; i++) begin
      tick(24'h200000 + 24'(i * 311), 24'h0, 1 + (i % 12));
      check("R7 dithered code varied n", got, exp);
    end
    for (int i = 0; i < 60; i++) begin
      tick(24'h600000 - 24'(i * 97), 24'hFFF000, 13 + (i % 3));
      check("R7 amplitude above max acts as 12", got, exp);
    end
  endtask

  task automatic testSpread();
    logic [15:0] lo, hi;
    int bad;
    lo = 16'hFFFF; hi = 16'h0000; bad = 0;
    for (int i = 0; i < 400; i++) begin
      tick(24'h800000, 24'h0, 11);
      if (got < lo) lo = got;
      if (got > hi) hi = got;
      if (got < 16'h7FF8 || got > 16'h8007) bad++;
    end
    check("R8 codes inside dither bound", 16'(bad), 16'd0);
    nChecks++;
    if (hi - lo < 4) begin
      nErrors++;
      $display("FAIL R8 spread: got %0d expected >= 4", hi - lo);
    end
  endtask

  task automatic testRepeat();
    logic [15:0] first [24];
    applyReset();
    for (int i = 0; i < 24; i++) begin
      tick(24'h3C0000 + 24'(i * 4099), 24'h000500, 10);
      first[i] = got;
    end
    applyReset();
    for (int i = 0; i < 24; i++) begin
      tick(24'h3C0000 + 24'(i * 4099), 24'h000500, 10);
      check("R9 repeat after reset", got, first[i]);
    end
    check("R9 R10 running sequence matches model", got, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    mA = SEEDA; mB = SEEDB; mRun = 1'b0; mLast = '0;
    testReset();
    testPassThrough();
    testOffset();
    testSaturation();
    testDitherModel();
    testSpread();
    testRepeat();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule